// File: doc/BRIEF.md
# Dual-Channel Serial Converter Register Front-End

This block is the digital slave side of a two-channel, 8-bit voltage-output converter. A host shifts a 16-bit word in on a serial clock and data line while a frame-select line is held low. An upper control byte and a lower data byte make up the word. When the frame-select line returns high, the block decodes the control byte. Depending on that decode, it loads the per-channel input (holding) registers, loads the converter (output) registers, or moves holding contents into the output registers. The same frame also sets the reference-select flag and two independent power-down flags.

All three serial inputs are sampled with the system clock `clk_i` through a synchronizer chain, so the serial clock must be several times slower than `clk_i`. A frame whose edge count is not exactly 16 is thrown away. After reset both holding registers are zero, and the outputs follow the holding registers until the first accepted frame. From then on, the outputs change only when the decode table says so.

Top module: `dual_dac_frontend`

## Requirements
- R1: While `fs_ni` is low, each rising edge of `sclk_i` shifts `sdi_i` into the frame, first bit received is bit 15. A frame may be sent as one 16-bit burst, or as two 8-bit bursts with `fs_ni` kept low between them.
- R2: Nothing changes state except on the rising edge of `fs_ni` after exactly 16 serial clock edges. Any other count discards the frame and leaves all outputs unchanged.
- R3: Frame bit 13 = 0 with operation field bits [9:8] = 00: both output registers take the data byte (bits 7..0), whatever bit 10 says. The holding registers are untouched.
- R4: Bit 13 = 0, bits [9:8] = 01: only the holding register of the channel picked by bit 10 (0 = channel A, 1 = channel B) takes the data byte. The outputs do not move.
- R5: Bit 13 = 0, bits [9:8] = 10: the picked channel's output register copies its holding register. The data byte is not used.
- R6: Bit 13 = 0, bits [9:8] = 11: the picked channel's output register takes the data byte directly. The other channel is unchanged.
- R7: Bit 13 = 1: the picked channel's holding register takes the data byte, and both output registers load from their holding registers at the same time. Bits [9:8] are ignored.
- R8: Every accepted frame sets `ref_ext_o` from bit 15, `pd_b_o` from bit 12 and `pd_a_o` from bit 11. Bit 14 has no effect. Power-down flags never alter register contents.
- R9: After reset, both holding registers are zero and the outputs follow them (so they read zero), and all flags are zero. This holds until the first accepted frame. That frame ends this mode for both channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to sample the serial lines |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data, captured on the serial clock's rising edge |
| fs_ni | input | 1 | Active-low frame select; its rising edge executes the frame |
| dac_a_o | output | 8 | Channel A converter code |
| dac_b_o | output | 8 | Channel B converter code |
| ref_ext_o | output | 1 | 1 selects the external reference, 0 the internal one |
| pd_a_o | output | 1 | Channel A power-down |
| pd_b_o | output | 1 | Channel B power-down |

## Verification
The bench pushes frames that are one bit short and one bit long. A counter that fires on "at least 16" would then accept a shifted word and corrupt both outputs. The load-both mode is sent with its operation bits set to values that would mean something else, to catch a decoder that looks at those bits. A power-down frame is followed by a holding-to-output copy, which shows whether power-down wiped the holding register. After a mid-run reset, a holding-only write must leave the outputs at zero and a later copy must bring the value out. A design whose transparent mode outlived the first frame would show the value one frame too early.

// File: rtl/dual_dac_pkg.sv
package dual_dac_pkg;
  localparam int DATA_W  = 8;
  localparam int CTRL_W  = 8;
  localparam int FRAME_W = CTRL_W + DATA_W;
  localparam int NCH     = 2;

  typedef enum logic [1:0] {
    OP_BOTH_DIRECT  = 2'b00,
    OP_LOAD_HOLD    = 2'b01,
    OP_HOLD_TO_OUT  = 2'b10,
    OP_SEL_DIRECT   = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    SRC_KEEP = 2'b00,
    SRC_DATA = 2'b01,
    SRC_HOLD = 2'b10
  } out_src_e;

  typedef struct packed {
    logic              ref_ext;
    logic              spare;
    logic              load_all;
    logic              pd_b;
    logic              pd_a;
    logic              sel_b;
    op_e               op;
    logic [DATA_W-1:0] data;
  } frame_t;
endpackage

// File: rtl/dual_dac_sync.sv
module dual_dac_sync #(
  parameter int           W       = 3,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/dual_dac_shifter.sv
module dual_dac_shifter #(
  parameter int FRAME_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sclk_s_i,
  input  logic               sdi_s_i,
  input  logic               fs_s_ni,
  output logic               fire_o,
  output logic [FRAME_W-1:0] frame_o
);
  localparam int              CNT_W   = $clog2(FRAME_W + 1) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_OK  = CNT_W'(FRAME_W);

  logic               sclk_d_q, fs_d_q;
  logic [FRAME_W-1:0] shreg_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               sclk_rise, fs_rise;

  assign sclk_rise = sclk_s_i & ~sclk_d_q;
  assign fs_rise   = fs_s_ni & ~fs_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d_q <= 1'b0;
      fs_d_q   <= 1'b1;
      shreg_q  <= '0;
      cnt_q    <= '0;
    end else begin
      sclk_d_q <= sclk_s_i;
      fs_d_q   <= fs_s_ni;
      if (fs_s_ni) begin
        cnt_q <= '0;
      end else if (sclk_rise) begin
        shreg_q <= {shreg_q[FRAME_W-2:0], sdi_s_i};
        if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // exact count only; short or long frames are dropped
  assign fire_o  = fs_rise && (cnt_q == CNT_OK);
  assign frame_o = shreg_q;
endmodule

// File: rtl/dual_dac_decode.sv
module dual_dac_decode
  import dual_dac_pkg::*;
#(
  parameter int N = 2
) (
  input  logic                 fire_i,
  input  frame_t               frm_i,
  output logic     [N-1:0]     ld_hold_o,
  output out_src_e [N-1:0]     src_o
);
  logic unused_spare;
  assign unused_spare = frm_i.spare;

  always_comb begin
    for (int c = 0; c < N; c++) begin
      logic is_sel;
      is_sel       = (int'(frm_i.sel_b) == c);
      ld_hold_o[c] = 1'b0;
      src_o[c]     = SRC_KEEP;
      if (fire_i) begin
        if (frm_i.load_all) begin
          ld_hold_o[c] = is_sel;
          src_o[c]     = is_sel ? SRC_DATA : SRC_HOLD;
        end else begin
          unique case (frm_i.op)
            OP_BOTH_DIRECT: src_o[c]     = SRC_DATA;
            OP_LOAD_HOLD:   ld_hold_o[c] = is_sel;
            OP_HOLD_TO_OUT: src_o[c]     = is_sel ? SRC_HOLD : SRC_KEEP;
            OP_SEL_DIRECT:  src_o[c]     = is_sel ? SRC_DATA : SRC_KEEP;
            default:        src_o[c]     = SRC_KEEP;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/dual_dac_channel.sv
module dual_dac_channel
  import dual_dac_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_hold_i,
  input  out_src_e     src_i,
  input  logic [W-1:0] data_i,
  input  logic         transp_i,
  output logic [W-1:0] hold_o,
  output logic [W-1:0] out_o
);
  logic [W-1:0] hold_q, out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      out_q  <= '0;
    end else begin
      if (ld_hold_i) hold_q <= data_i;
      unique case (src_i)
        SRC_DATA: out_q <= data_i;
        SRC_HOLD: out_q <= hold_q;
        default:  out_q <= out_q;
      endcase
    end
  end

  assign hold_o = hold_q;
  assign out_o  = transp_i ? hold_q : out_q;
endmodule

// File: rtl/dual_dac_frontend.sv
module dual_dac_frontend
  import dual_dac_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sdi_i,
  input  logic              fs_ni,
  output logic [DATA_W-1:0] dac_a_o,
  output logic [DATA_W-1:0] dac_b_o,
  output logic              ref_ext_o,
  output logic              pd_a_o,
  output logic              pd_b_o
);
  logic [2:0]          pins_s;
  logic                frame_fire;
  logic [FRAME_W-1:0]  frame_bits;
  frame_t              frm;
  logic     [NCH-1:0]  ld_hold;
  out_src_e [NCH-1:0]  src;
  logic [DATA_W-1:0]   hold_q [NCH];
  logic [DATA_W-1:0]   out_v  [NCH];
  logic                transp_q, ref_q, pda_q, pdb_q;

  dual_dac_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({fs_ni, sclk_i, sdi_i}),
    .q_o   (pins_s)
  );

  dual_dac_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sclk_s_i(pins_s[1]),
    .sdi_s_i (pins_s[0]),
    .fs_s_ni (pins_s[2]),
    .fire_o  (frame_fire),
    .frame_o (frame_bits)
  );

  assign frm = frame_t'(frame_bits);

  dual_dac_decode #(.N(NCH)) u_dec (
    .fire_i   (frame_fire),
    .frm_i    (frm),
    .ld_hold_o(ld_hold),
    .src_o    (src)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dual_dac_channel #(.W(DATA_W)) u_ch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .ld_hold_i(ld_hold[c]),
      .src_i    (src[c]),
      .data_i   (frm.data),
      .transp_i (transp_q),
      .hold_o   (hold_q[c]),
      .out_o    (out_v[c])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      transp_q <= 1'b1;
      ref_q    <= 1'b0;
      pda_q    <= 1'b0;
      pdb_q    <= 1'b0;
    end else if (frame_fire) begin
      transp_q <= 1'b0;
      ref_q    <= frm.ref_ext;
      pda_q    <= frm.pd_a;
      pdb_q    <= frm.pd_b;
    end
  end

  assign dac_a_o   = out_v[0];
  assign dac_b_o   = out_v[1];
  assign ref_ext_o = ref_q;
  assign pd_a_o    = pda_q;
  assign pd_b_o    = pdb_q;
endmodule

// File: rtl/dual_dac_frontend_chk.sv
module dual_dac_frontend_chk
  import dual_dac_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               fire_i,
  input logic [FRAME_W-1:0] frame_i,
  input logic [DATA_W-1:0]  hold_a_i,
  input logic [DATA_W-1:0]  hold_b_i,
  input logic               transp_i,
  input logic [DATA_W-1:0]  dac_a_i,
  input logic [DATA_W-1:0]  dac_b_i,
  input logic               ref_ext_i,
  input logic               pd_a_i,
  input logic               pd_b_i
);
  AST_HOLD_WITHOUT_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fire_i |=> $stable(dac_a_i) && $stable(dac_b_i) && $stable(ref_ext_i) && $stable(pd_a_i) && $stable(pd_b_i)); // R2

  AST_BOTH_DIRECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i && !frame_i[13] && frame_i[9:8] == 2'b00
    |=> dac_a_i == $past(frame_i[DATA_W-1:0]) && dac_b_i == $past(frame_i[DATA_W-1:0])); // R3

  AST_HOLD_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i && !frame_i[13] && frame_i[9:8] == 2'b01 |=> $stable(dac_a_i) && $stable(dac_b_i)); // R4

  AST_SEL_DIRECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i && !frame_i[13] && frame_i[9:8] == 2'b11
    |=> (($past(frame_i[10]) ? dac_b_i : dac_a_i) == $past(frame_i[DATA_W-1:0]))); // R6

  AST_LOAD_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i && frame_i[13]
    |=> dac_a_i == $past(frame_i[10] ? hold_a_i : frame_i[DATA_W-1:0])
     && dac_b_i == $past(frame_i[10] ? frame_i[DATA_W-1:0] : hold_b_i)); // R7

  AST_FLAGS_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |=> {ref_ext_i, pd_b_i, pd_a_i} == $past({frame_i[15], frame_i[12], frame_i[11]})); // R8

  AST_TRANSP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    transp_i |-> dac_a_i == '0 && dac_b_i == '0); // R9

  AST_TRANSP_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |=> !transp_i); // R9
endmodule

bind dual_dac_frontend dual_dac_frontend_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .fire_i   (frame_fire),
  .frame_i  (frame_bits),
  .hold_a_i (hold_q[0]),
  .hold_b_i (hold_q[1]),
  .transp_i (transp_q),
  .dac_a_i  (dac_a_o),
  .dac_b_i  (dac_b_o),
  .ref_ext_i(ref_ext_o),
  .pd_a_i   (pd_a_o),
  .pd_b_i   (pd_b_o)
);

// File: tb/dual_dac_frontend_bench.sv
module dual_dac_frontend_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_SCLK  = 4;
  localparam int NVEC       = 10;
  // {frame, two_burst, exp_a, exp_b, {ref, pd_b, pd_a}}
  localparam logic [35:0] VEC [NVEC] = '{
    {16'h003C, 1'b0, 8'h3C, 8'h3C, 3'b000},
    {16'h055A, 1'b1, 8'h3C, 8'h3C, 3'b000},
    {16'h06FF, 1'b0, 8'h3C, 8'h5A, 3'b000},
    {16'h8B81, 1'b1, 8'h81, 8'h5A, 3'b101},
    {16'h2210, 1'b0, 8'h10, 8'h5A, 3'b000},
    {16'h11EE, 1'b1, 8'h10, 8'h5A, 3'b010},
    {16'h0577, 1'b0, 8'h10, 8'h5A, 3'b000},
    {16'h6799, 1'b1, 8'hEE, 8'h99, 3'b000},
    {16'h1C00, 1'b0, 8'h00, 8'h00, 3'b011},
    {16'h0200, 1'b1, 8'hEE, 8'h00, 3'b000}
  };

  logic clk = 1'b0, rst_ni = 1'b0, sclk = 1'b0, sdi = 1'b0, fs_n = 1'b1;
  logic [7:0] dac_a, dac_b;
  logic ref_ext, pd_a, pd_b;
  int checks = 0, errors = 0;

  logic [7:0] m_hold [2];
  logic [7:0] m_out  [2];
  logic m_transp, m_ref, m_pda, m_pdb;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_dac_frontend u_dual_dac_frontend (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk), .sdi_i(sdi), .fs_ni(fs_n),
    .dac_a_o(dac_a), .dac_b_o(dac_b), .ref_ext_o(ref_ext), .pd_a_o(pd_a), .pd_b_o(pd_b)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string vreq(input int i);
    case (i)
      0: return "R3";  1: return "R4";  2: return "R5";  3: return "R6";
      4: return "R7";  5: return "R4";  6: return "R4";  7: return "R7";
      8: return "R8";  default: return "R5";
    endcase
  endfunction

  task automatic model_reset();
    m_hold[0] = '0; m_hold[1] = '0; m_out[0] = '0; m_out[1] = '0;
    m_transp = 1'b1; m_ref = 1'b0; m_pda = 1'b0; m_pdb = 1'b0;
  endtask

  task automatic model_apply(input logic [15:0] f);
    int s;
    logic [7:0] d;
    s = int'(f[10]);
    d = f[7:0];
    if (f[13]) begin
      m_hold[s] = d;
      m_out[0] = m_hold[0];
      m_out[1] = m_hold[1];
    end else begin
      case (f[9:8])
        2'b00: begin m_out[0] = d; m_out[1] = d; end
        2'b01: m_hold[s] = d;
        2'b10: m_out[s] = m_hold[s];
        default: m_out[s] = d;
      endcase
    end
    m_transp = 1'b0;
    m_ref = f[15]; m_pdb = f[12]; m_pda = f[11];
  endtask

  function automatic logic [7:0] m_exp(input int c);
    return m_transp ? m_hold[c] : m_out[c];
  endfunction

  task automatic send(input logic [31:0] word, input int nbits, input bit split);
    fs_n = 1'b0;
    wait_clk(HALF_SCLK);
    for (int i = nbits - 1; i >= 0; i--) begin
      sdi = word[i];
      wait_clk(HALF_SCLK);
      sclk = 1'b1;
      wait_clk(HALF_SCLK);
      sclk = 1'b0;
      if (split && i == nbits - 8) wait_clk(12);
    end
    wait_clk(HALF_SCLK);
    fs_n = 1'b1;
    wait_clk(10);
  endtask

  task automatic check_model(input string req, input string what);
    chk(dac_a == m_exp(0), req, {what, " dac_a"}, int'(dac_a), int'(m_exp(0)));
    chk(dac_b == m_exp(1), req, {what, " dac_b"}, int'(dac_b), int'(m_exp(1)));
    chk({ref_ext, pd_b, pd_a} == {m_ref, m_pdb, m_pda}, "R8", {what, " flags"},
        int'({ref_ext, pd_b, pd_a}), int'({m_ref, m_pdb, m_pda}));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    wait_clk(3);
    // R9: reset state
    chk(dac_a == 8'h00 && dac_b == 8'h00, "R9", "reset outputs", int'({dac_a, dac_b}), 0);
    chk({ref_ext, pd_b, pd_a} == 3'b000, "R9", "reset flags", int'({ref_ext, pd_b, pd_a}), 0);
    rst_ni = 1'b1;
    wait_clk(3);

    // R1 (one and two bursts) with decode table R3..R8
    for (int v = 0; v < NVEC; v++) begin
      send({16'h0, VEC[v][35:20]}, 16, VEC[v][19]);
      model_apply(VEC[v][35:20]);
      chk(dac_a == VEC[v][18:11], vreq(v), $sformatf("vector %0d dac_a", v), int'(dac_a), int'(VEC[v][18:11]));
      chk(dac_b == VEC[v][10:3],  vreq(v), $sformatf("vector %0d dac_b", v), int'(dac_b), int'(VEC[v][10:3]));
      chk({ref_ext, pd_b, pd_a} == VEC[v][2:0], "R8", $sformatf("vector %0d flags", v),
          int'({ref_ext, pd_b, pd_a}), int'(VEC[v][2:0]));
    end

    // R2: wrong lengths discarded
    send(32'h0000_0055, 15, 1'b0);
    check_model("R2", "15-bit frame");
    send(32'h0001_8855, 17, 1'b1);
    check_model("R2", "17-bit frame");
    send(32'h0, 0, 1'b0);
    check_model("R2", "empty frame");

    // R9: reset mid-run, transparency ends on first frame
    wait_clk(1);
    rst_ni = 1'b0;
    wait_clk(3);
    model_reset();
    chk(dac_a == 8'h00 && dac_b == 8'h00, "R9", "second reset outputs", int'({dac_a, dac_b}), 0);
    rst_ni = 1'b1;
    wait_clk(3);
    send(32'h0000_0142, 16, 1'b0);
    model_apply(16'h0142);
    chk(dac_a == 8'h00, "R9", "first frame hold-only dac_a", int'(dac_a), 0);
    send(32'h0000_0200, 16, 1'b1);
    model_apply(16'h0200);
    chk(dac_a == 8'h42, "R9", "copy after first frame dac_a", int'(dac_a), 8'h42);

    // R1: random frames against model
    for (int n = 0; n < 40; n++) begin
      logic [15:0] f;
      bit sp;
      f  = 16'($urandom);
      sp = 1'($urandom);
      send({16'h0, f}, 16, sp);
      model_apply(f);
      check_model("R1", $sformatf("random frame %0h", f));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule